// File: doc/BRIEF.md
# UART Diagnostic Loopback Controller

This block sits between a UART's transmit and receive engines and the two serial pins. It routes the serial lines in one of four ways, chosen by a 2-bit mode input. Normal mode connects the core straight to the pins. Auto echo sends the incoming line back out of the transmit pin while the receiver still sees it. Local loop feeds the core's transmit output into its own receiver and holds the external transmit pin at mark. Remote loop returns line data straight to the line and keeps the core receiver idle.

Independently of the routing, an echo checker can be switched on. Each character the core transmits, marked by a transmit strobe, goes into a small queue. Each character the core receives, marked by a receive strobe, is compared with the oldest queued character, and that entry is then removed. Because a remote station takes time to echo, a queued character may wait up to a programmable number of bit times before it counts as lost. A wrong echo or a lost echo sets a sticky status flag, and the interrupt follows the flags.

Top module: `uart_loop_ctrl`

## Requirements
- R1: After reset err_mismatch, err_timeout and irq are 0 and the echo queue is empty.
- R2: With cfg_mode = 2'b00 (normal), line_txd equals core_txd and core_rxd equals line_rxd.
- R3: With cfg_mode = 2'b01 (auto echo), line_txd and core_rxd both equal line_rxd.
- R4: With cfg_mode = 2'b10 (local loop), core_rxd equals core_txd and line_txd is held at 1.
- R5: With cfg_mode = 2'b11 (remote loop), line_txd equals line_rxd and core_rxd is held at 1.
- R6: While cfg_chk_en is 1, in any mode, a tx_stb cycle appends tx_chr to a 4-entry queue. A push into a full queue that is not being popped in the same cycle is dropped. A rx_stb cycle compares rx_chr with the oldest entry and removes that entry.
- R7: err_mismatch sets on the clock edge after a compared rx_chr differs from the oldest entry, and also after a rx_stb that arrives while the queue is empty.
- R8: Each queued entry counts bit_tick pulses from its push. When the oldest entry's count reaches cfg_tmo_lim (at least 1), err_timeout sets on the next edge and the entry is removed. A rx_stb in that same cycle is discarded without a compare.
- R9: Both flags are sticky. Writing stat_clr[0] = 1 clears err_mismatch and stat_clr[1] = 1 clears err_timeout. If a flag is set and cleared in the same cycle, the set wins.
- R10: irq is 1 exactly when err_mismatch or err_timeout is 1.
- R11: While cfg_chk_en is 0 the queue is emptied, the strobes are ignored and no flag sets. The clear inputs still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Line routing mode (00 normal, 01 auto echo, 10 local loop, 11 remote loop) |
| cfg_chk_en | input | 1 | Enables the echo checker |
| cfg_tmo_lim | input | 8 | Bit times an entry may wait for its echo |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_stb | input | 1 | Core has sent a character |
| tx_chr | input | 8 | Character sent |
| rx_stb | input | 1 | Core has received a character |
| rx_chr | input | 8 | Character received |
| stat_clr | input | 2 | Write-1-to-clear: bit 0 mismatch, bit 1 timeout |
| core_txd | input | 1 | Serial output of the UART transmitter |
| core_rxd | output | 1 | Serial input to the UART receiver |
| line_rxd | input | 1 | Receive pin |
| line_txd | output | 1 | Transmit pin |
| err_mismatch | output | 1 | Sticky wrong-echo or unexpected-echo flag |
| err_timeout | output | 1 | Sticky lost-echo flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the strobes are single-cycle, that bit_tick is a synchronous pulse and that cfg_tmo_lim is at least 1 whenever checking is on. They also assume the checker alone drives the queue's push and pop controls, so a pop is only requested when an entry exists. The stimulus uses a fixed limit of 5 and drives every input half a cycle away from the sampling edge. The random phase takes receive characters half from the reference queue's head and half at random, so matches, mismatches, timeouts and full-queue drops all occur.

// File: rtl/uart_loop_pkg.sv
package uart_loop_pkg;

    typedef enum logic [1:0] {
        LM_NORMAL = 2'b00,
        LM_ECHO   = 2'b01,
        LM_LOCAL  = 2'b10,
        LM_REMOTE = 2'b11
    } loop_mode_e;

    localparam int CHAR_W_DEF = 8;
    localparam int AGE_W_DEF  = 8;
    localparam int DEPTH_DEF  = 4;

endpackage

// File: rtl/uart_loop_mux.sv
module uart_loop_mux
    import uart_loop_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       core_txd,
    input  logic       line_rxd,
    output logic       core_rxd,
    output logic       line_txd
);

    loop_mode_e mode_e;

    always_comb begin
        mode_e = loop_mode_e'(mode);
        case (mode_e)
            LM_NORMAL: begin
                line_txd = core_txd;
                core_rxd = line_rxd;
            end
            LM_ECHO: begin
                line_txd = line_rxd;
                core_rxd = line_rxd;
            end
            LM_LOCAL: begin
                line_txd = 1'b1;
                core_rxd = core_txd;
            end
            default: begin
                line_txd = line_rxd;
                core_rxd = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/uart_echo_queue.sv
module uart_echo_queue #(
    parameter int DEPTH  = 4,
    parameter int CHAR_W = 8,
    parameter int AGE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [CHAR_W-1:0] push_data,
    input  logic              pop,
    input  logic              tick,
    input  logic [AGE_W-1:0]  limit,
    output logic              head_vld,
    output logic [CHAR_W-1:0] head_data,
    output logic              head_expired,
    output logic              full
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    typedef struct packed {
        logic [DEPTH-1:0][CHAR_W-1:0] data;
        logic [DEPTH-1:0][AGE_W-1:0]  age;
        logic [CNT_W-1:0]             cnt;
    } q_state_t;

    q_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.cnt = '0;
        end else begin
            if (pop && st_q.cnt != '0) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    st_d.data[i] = st_q.data[i+1];
                    st_d.age[i]  = st_q.age[i+1];
                end
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (tick) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) < st_d.cnt && st_d.age[i] != AGE_MAX) begin
                        st_d.age[i] = st_d.age[i] + 1'b1;
                    end
                end
            end
            if (push && st_d.cnt < CNT_W'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) == st_d.cnt) begin
                        st_d.data[i] = push_data;
                        st_d.age[i]  = '0;
                    end
                end
                st_d.cnt = st_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_vld     = st_q.cnt != '0;
    assign head_data    = st_q.data[0];
    assign head_expired = head_vld && (st_q.age[0] >= limit);
    assign full         = st_q.cnt == CNT_W'(DEPTH);

    AST_POP_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_vld); // R6

    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop)); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !head_vld); // R11

endmodule

// File: rtl/uart_echo_check.sv
module uart_echo_check #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              tx_stb,
    input  logic              rx_stb,
    input  logic [CHAR_W-1:0] rx_chr,
    input  logic              head_vld,
    input  logic [CHAR_W-1:0] head_data,
    input  logic              head_expired,
    input  logic              full,
    input  logic [1:0]        stat_clr,
    output logic              push,
    output logic              pop,
    output logic              flush,
    output logic              err_mismatch,
    output logic              err_timeout
);

    typedef struct packed {
        logic mis;
        logic tmo;
    } flag_t;

    flag_t fl_d, fl_q;
    logic  set_mis, set_tmo;

    always_comb begin
        flush   = !chk_en;
        set_tmo = chk_en && head_vld && head_expired;
        pop     = chk_en && head_vld && (head_expired || rx_stb);
        set_mis = chk_en && rx_stb && !head_expired &&
                  (!head_vld || (rx_chr != head_data));
        push    = chk_en && tx_stb && (!full || pop);

        fl_d     = fl_q;
        fl_d.mis = set_mis || (fl_q.mis && !stat_clr[0]);
        fl_d.tmo = set_tmo || (fl_q.tmo && !stat_clr[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign err_mismatch = fl_q.mis;
    assign err_timeout  = fl_q.tmo;

    AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && rx_stb && head_vld && !head_expired && rx_chr != head_data)
        |=> err_mismatch); // R7

    AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && head_vld && head_expired) |=> err_timeout); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mismatch && !stat_clr[0]) |=> err_mismatch); // R9

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_en && !err_timeout && !err_mismatch) |=> (!err_timeout && !err_mismatch)); // R11

endmodule

// File: rtl/uart_loop_ctrl.sv
module uart_loop_ctrl
    import uart_loop_pkg::*;
#(
    parameter int DEPTH  = DEPTH_DEF,
    parameter int CHAR_W = CHAR_W_DEF,
    parameter int AGE_W  = AGE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_chk_en,
    input  logic [AGE_W-1:0]  cfg_tmo_lim,
    input  logic              bit_tick,
    input  logic              tx_stb,
    input  logic [CHAR_W-1:0] tx_chr,
    input  logic              rx_stb,
    input  logic [CHAR_W-1:0] rx_chr,
    input  logic [1:0]        stat_clr,
    input  logic              core_txd,
    output logic              core_rxd,
    input  logic              line_rxd,
    output logic              line_txd,
    output logic              err_mismatch,
    output logic              err_timeout,
    output logic              irq
);

    logic              q_push, q_pop, q_flush;
    logic              q_head_vld, q_head_exp, q_full;
    logic [CHAR_W-1:0] q_head_data;

    uart_loop_mux u_mux (
        .mode     (cfg_mode),
        .core_txd (core_txd),
        .line_rxd (line_rxd),
        .core_rxd (core_rxd),
        .line_txd (line_txd)
    );

    uart_echo_queue #(
        .DEPTH  (DEPTH),
        .CHAR_W (CHAR_W),
        .AGE_W  (AGE_W)
    ) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (q_flush),
        .push         (q_push),
        .push_data    (tx_chr),
        .pop          (q_pop),
        .tick         (bit_tick),
        .limit        (cfg_tmo_lim),
        .head_vld     (q_head_vld),
        .head_data    (q_head_data),
        .head_expired (q_head_exp),
        .full         (q_full)
    );

    uart_echo_check #(
        .CHAR_W (CHAR_W)
    ) u_check (
        .clk          (clk),
        .rst_n        (rst_n),
        .chk_en       (cfg_chk_en),
        .tx_stb       (tx_stb),
        .rx_stb       (rx_stb),
        .rx_chr       (rx_chr),
        .head_vld     (q_head_vld),
        .head_data    (q_head_data),
        .head_expired (q_head_exp),
        .full         (q_full),
        .stat_clr     (stat_clr),
        .push         (q_push),
        .pop          (q_pop),
        .flush        (q_flush),
        .err_mismatch (err_mismatch),
        .err_timeout  (err_timeout)
    );

    assign irq = err_mismatch || err_timeout;

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cfg_chk_en)); // R10

endmodule

// File: tb/sim_uart_loop_ctrl.sv
module sim_uart_loop_ctrl;

    logic       clk = 0;
    logic       rst_n = 1;
    logic [1:0] cfg_mode = 0;
    logic       cfg_chk_en = 0;
    logic [7:0] cfg_tmo_lim = 8'd5;
    logic       bit_tick = 0;
    logic       tx_stb = 0;
    logic [7:0] tx_chr = 0;
    logic       rx_stb = 0;
    logic [7:0] rx_chr = 0;
    logic [1:0] stat_clr = 0;
    logic       core_txd = 1;
    logic       line_rxd = 1;
    logic       core_rxd, line_txd, err_mismatch, err_timeout, irq;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int   m_n = 0;
    int   m_age [4];
    logic [7:0] m_dat [4];
    logic m_mis = 0, m_tmo = 0;
    logic m_sm, m_st, m_pop;

    uart_loop_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_chk_en(cfg_chk_en),
        .cfg_tmo_lim(cfg_tmo_lim), .bit_tick(bit_tick), .tx_stb(tx_stb),
        .tx_chr(tx_chr), .rx_stb(rx_stb), .rx_chr(rx_chr), .stat_clr(stat_clr),
        .core_txd(core_txd), .core_rxd(core_rxd), .line_rxd(line_rxd),
        .line_txd(line_txd), .err_mismatch(err_mismatch),
        .err_timeout(err_timeout), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_mis = 0; m_tmo = 0;
        end else begin
            m_sm = 0; m_st = 0; m_pop = 0;
            if (!cfg_chk_en) begin
                m_n = 0;
            end else begin
                if (m_n > 0 && m_age[0] >= int'(cfg_tmo_lim)) begin
                    m_st = 1; m_pop = 1;
                end else if (rx_stb) begin
                    if (m_n == 0) m_sm = 1;
                    else begin
                        if (rx_chr != m_dat[0]) m_sm = 1;
                        m_pop = 1;
                    end
                end
                if (m_pop) begin
                    for (int i = 0; i < 3; i++) begin
                        m_dat[i] = m_dat[i+1]; m_age[i] = m_age[i+1];
                    end
                    m_n--;
                end
                if (bit_tick) for (int i = 0; i < m_n; i++) m_age[i]++;
                if (tx_stb && m_n < 4) begin
                    m_dat[m_n] = tx_chr; m_age[m_n] = 0; m_n++;
                end
            end
            m_mis = m_sm | (m_mis & !stat_clr[0]);
            m_tmo = m_st | (m_tmo & !stat_clr[1]);
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        logic et, er;
        string rq;
        case (cfg_mode)
            2'b00: begin et = core_txd; er = line_rxd; rq = "R2"; end
            2'b01: begin et = line_rxd; er = line_rxd; rq = "R3"; end
            2'b10: begin et = 1'b1;     er = core_txd; rq = "R4"; end
            default: begin et = line_rxd; er = 1'b1;   rq = "R5"; end
        endcase
        chk(line_txd === et, {rq, " line_txd"}, line_txd, et);
        chk(core_rxd === er, {rq, " core_rxd"}, core_rxd, er);
        chk(err_mismatch === m_mis, "R7 err_mismatch", err_mismatch, m_mis);
        chk(err_timeout === m_tmo, "R8 err_timeout", err_timeout, m_tmo);
        chk(irq === (m_mis | m_tmo), "R10 irq", irq, m_mis | m_tmo);
    end

    task automatic step(input logic t, input logic [7:0] tc, input logic r,
                        input logic [7:0] rc, input logic tk, input logic [1:0] cl);
        tx_stb = t; tx_chr = tc; rx_stb = r; rx_chr = rc; bit_tick = tk; stat_clr = cl;
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic clear_all();
        step(0, 0, 0, 0, 0, 2'b11);
    endtask

    initial begin
        #(200000 * 8);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1 rst_n = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(err_mismatch === 0 && err_timeout === 0 && irq === 0, "R1 reset flags",
            {err_mismatch, err_timeout, irq}, 0);
        rst_n = 1;
        idle(1);
        chk(irq === 0, "R1 after reset release", irq, 0);

        // routing modes R2 R3 R4 R5
        for (int m = 0; m < 4; m++) begin
            cfg_mode = 2'(m);
            for (int p = 0; p < 4; p++) begin
                core_txd = p[0]; line_rxd = p[1];
                idle(1);
            end
        end
        cfg_mode = 2'b10; core_txd = 0; line_rxd = 0; idle(1);
        chk(line_txd === 1'b1, "R4 line idles at mark", line_txd, 1);
        core_txd = 1; line_rxd = 1; cfg_mode = 2'b00;

        // R6 matching echoes
        cfg_chk_en = 1; idle(1);
        step(1, 8'h41, 0, 0, 0, 0);
        step(1, 8'h42, 0, 0, 1, 0);
        step(0, 0, 1, 8'h41, 0, 0);
        step(0, 0, 1, 8'h42, 0, 0);
        idle(1);
        chk(err_mismatch === 0 && err_timeout === 0, "R6 matching echoes", err_mismatch, 0);

        // R7 wrong echo, R10 irq, R9 clear
        step(1, 8'h43, 0, 0, 0, 0);
        step(0, 0, 1, 8'h44, 0, 0);
        chk(err_mismatch === 1, "R7 wrong echo", err_mismatch, 1);
        chk(irq === 1, "R10 irq on mismatch", irq, 1);
        idle(3);
        chk(err_mismatch === 1, "R9 sticky", err_mismatch, 1);
        step(0, 0, 0, 0, 0, 2'b10);
        chk(err_mismatch === 1, "R9 other clear bit no effect", err_mismatch, 1);
        step(0, 0, 0, 0, 0, 2'b01);
        chk(err_mismatch === 0 && irq === 0, "R9 write-1 clear", err_mismatch, 0);

        // R7 unexpected echo with empty queue
        step(0, 0, 1, 8'h55, 0, 0);
        chk(err_mismatch === 1, "R7 echo with empty queue", err_mismatch, 1);
        clear_all();

        // R6 full queue drops fifth push
        for (int i = 0; i < 5; i++) step(1, 8'(8'h60 + i), 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 8'(8'h60 + i), 0, 0);
        idle(1);
        chk(err_mismatch === 0, "R6 four queued echoes match", err_mismatch, 0);
        step(0, 0, 1, 8'h64, 0, 0);
        chk(err_mismatch === 1, "R6 fifth push was dropped", err_mismatch, 1);
        clear_all();

        // R8 timeout after 5 bit times
        step(1, 8'h70, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0);
        chk(err_timeout === 0, "R8 no timeout before limit", err_timeout, 0);
        step(0, 0, 0, 0, 1, 0);
        chk(err_timeout === 0, "R8 limit reached, flag next edge", err_timeout, 0);
        idle(1);
        chk(err_timeout === 1 && irq === 1, "R8 timeout set", err_timeout, 1);
        step(0, 0, 1, 8'h70, 0, 0);
        chk(err_mismatch === 1, "R8 late echo finds empty queue", err_mismatch, 1);
        clear_all();

        // R9 set wins over clear
        step(0, 0, 1, 8'h11, 0, 2'b01);
        chk(err_mismatch === 1, "R9 set wins over clear", err_mismatch, 1);
        clear_all();

        // R11 disabled checker ignores strobes and flushes
        step(1, 8'h21, 0, 0, 0, 0);
        cfg_chk_en = 0;
        step(1, 8'h22, 1, 8'h99, 1, 0);
        idle(8);
        chk(err_mismatch === 0 && err_timeout === 0, "R11 no flags while off", err_mismatch, 0);
        cfg_chk_en = 1;
        step(0, 0, 1, 8'h21, 0, 0);
        chk(err_mismatch === 1, "R11 queue emptied while off", err_mismatch, 1);
        clear_all();

        // random phase, compared every cycle
        for (int i = 0; i < 3000; i++) begin
            logic t, r, tk;
            logic [7:0] rc;
            t  = ($urandom % 3) == 0;
            r  = ($urandom % 3) == 0;
            tk = ($urandom % 2) == 0;
            rc = (($urandom % 2) == 0 && m_n > 0) ? m_dat[0] : 8'($urandom % 4);
            cfg_mode = 2'($urandom % 4);
            core_txd = 1'($urandom); line_rxd = 1'($urandom);
            if (($urandom % 200) == 0) cfg_chk_en = ~cfg_chk_en;
            step(t, 8'($urandom % 4), r, rc, tk, 2'(($urandom % 8 == 0) ? $urandom % 4 : 0));
        end
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule